// File: doc/BRIEF.md
# Multi-Source Reset Supervisor Sequencer

This block turns several reset causes into one active-low system reset. Its inputs are up to three undervoltage flags and an active-low push-button input. Each undervoltage flag comes from an external comparator and reaches the block already synchronized. Every delay is a count of clock cycles and is set by a parameter. Analog thresholds, hysteresis and capacitor timing are outside the block.

A supply flag counts as bad only after it has stayed high for that source's own assertion latency. A source that is not enabled is treated as always good. The button input is glitch filtered. It can also be built to need a continuous hold time before it triggers a reset. While any source is bad or the button is qualified, the reset is active. After all of them clear, the reset stays active for a recovery interval. That interval must pass without interruption: any new request starts it again from zero. The reset is also active after power-on and is released only after one full recovery interval.

The output can be built push-pull or open-drain. In both styles it is given as a level and a drive enable. A status vector records which sources were active when the most recent request began.

Top module: `rst_supervisor`

## Requirements
- R1: After the asynchronous reset `rst_ni` releases with no source active, the system reset remains active for exactly REC_CYC clock edges and is then released.
- R2: An enabled undervoltage flag `uv_flag_i[i]` asserts the system reset once it has been sampled high on LAT_CYC[16*i +: 16] consecutive edges. A shorter high run has no effect. Each source has its own latency.
- R3: A source whose bit in SRC_EN is 0 never affects the system reset or the cause vector, whatever its flag does.
- R4: A low run on `mr_ni` shorter than MR_FILT_CYC sampled edges has no effect. A low run of MR_FILT_CYC edges asserts the system reset.
- R5: With HOLD_EN=1, the button needs a continuous low run of MR_FILT_CYC+HOLD_CYC edges. A release before that clears the count, and no reset is produced.
- R6: The system reset is active in every cycle in which any qualified source is active. After all sources clear, it stays active for REC_CYC more edges.
- R7: A request that occurs during the recovery interval restarts the interval from zero.
- R8: Push-pull style (OPEN_DRAIN=0): `rst_oe_o` is always 1. `sys_rst_no` is 0 while reset is active and 1 when it is released.
- R9: Open-drain style (OPEN_DRAIN=1): `sys_rst_no` is always 0. `rst_oe_o` is 1 while reset is active and 0 (line released) otherwise.
- R10: `cause_o` is 0 after reset. Bit i marks supply source i and bit NSRC marks the button. The vector loads the set of qualified sources one cycle after the request goes from none to any, and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| uv_flag_i | input | NSRC | Synchronized undervoltage flags, 1 = supply bad |
| mr_ni | input | 1 | Push-button reset, active low |
| sys_rst_no | output | 1 | System reset level, active low |
| rst_oe_o | output | 1 | Drive enable for the reset line |
| cause_o | output | NSRC+1 | Sources active at the start of the latest request |

## Verification
The bench builds two instances with small counts: latencies of 3, 5 and 4 cycles, a filter of 4 cycles, a hold of 10 cycles and a recovery of 20 cycles. At these sizes the exact edge of every release, filter threshold and restart can be reached within a few dozen cycles. Source 2 is disabled in both instances, so the handling of an unused source is exercised with a live flag. One instance is push-pull without hold qualification. The other is open-drain with hold qualification, so both output styles and both button variants run against the same supply stimulus.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
  // Defaults assume a 125 MHz clock (8 ns).
  localparam int unsigned DEF_REC_CYC  = 26_250_000; // 210 ms
  localparam int unsigned DEF_FILT_CYC = 64;         // 512 ns: rejects <100 ns, accepts 1 us
  localparam int unsigned DEF_HOLD_CYC = 750;        // 6 us minimum hold
  localparam int unsigned LAT_W        = 16;         // width of one latency field
endpackage

// File: rtl/rst_sup_src_gate.sv
module rst_sup_src_gate #(
  parameter int unsigned LAT = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic bad_o
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;
  logic          bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else if (!flag_i) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else begin
      if (cnt_q != CW'(LAT)) cnt_q <= cnt_q + 1'b1;
      bad_q <= (cnt_q >= CW'(LAT - 1));
    end
  end

  assign bad_o = bad_q;

  AST_SRC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_i |=> !bad_o); // R2
  AST_SRC_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bad_o) |-> $past(flag_i)); // R2
endmodule

// File: rtl/rst_sup_btn_qual.sv
module rst_sup_btn_qual #(
  parameter int unsigned FILT_CYC = 64,
  parameter int unsigned HOLD_CYC = 750,
  parameter bit          HOLD_EN  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mr_ni,
  output logic pressed_o
);
  localparam int unsigned THR = FILT_CYC + (HOLD_EN ? HOLD_CYC : 0);
  localparam int unsigned CW  = $clog2(THR + 1);

  logic [CW-1:0] low_cnt_q;
  logic          pressed_q;

  // One run counter covers both glitch rejection and hold qualification.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      pressed_q <= 1'b0;
    end else if (mr_ni) begin
      low_cnt_q <= '0;
      pressed_q <= 1'b0;
    end else begin
      if (low_cnt_q != CW'(THR)) low_cnt_q <= low_cnt_q + 1'b1;
      pressed_q <= (low_cnt_q >= CW'(THR - 1));
    end
  end

  assign pressed_o = pressed_q;

  AST_BTN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_ni |=> !pressed_o); // R4
  AST_BTN_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pressed_o) |-> $past(!mr_ni)); // R5
endmodule

// File: rtl/rst_sup_recovery.sv
module rst_sup_recovery #(
  parameter int unsigned REC_CYC = 26_250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(REC_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (req_i) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (hold_q) begin
      if (cnt_q == CW'(REC_CYC - 1)) begin
        cnt_q  <= '0;
        hold_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = req_i | hold_q;

  AST_REC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (cnt_q == '0) && active_o); // R7
  AST_REC_CLEAN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> !req_i && $past(!req_i)); // R6
endmodule

// File: rtl/rst_sup_cause.sv
module rst_sup_cause #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] cause_o
);
  logic         req_q;
  logic [W-1:0] cause_q;
  logic         req_any;

  assign req_any = |src_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      req_q <= req_any;
      if (req_any && !req_q) cause_q <= src_i;
    end
  end

  assign cause_o = cause_q;

  AST_CAUSE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_any && !req_q) |=> $stable(cause_o)); // R10
  AST_CAUSE_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_any && !req_q) |=> (cause_o != '0)); // R10
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_sup_pkg::*;
#(
  parameter int unsigned          NSRC      = 3,
  parameter logic [NSRC-1:0]      SRC_EN    = '1,
  parameter logic [NSRC*16-1:0]   LAT_CYC   = {16'd2750, 16'd2500, 16'd2500},
  parameter int unsigned          FILT_CYC  = DEF_FILT_CYC,
  parameter int unsigned          HOLD_CYC  = DEF_HOLD_CYC,
  parameter bit                   HOLD_EN   = 1'b0,
  parameter int unsigned          REC_CYC   = DEF_REC_CYC,
  parameter bit                   OPEN_DRAIN = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] uv_flag_i,
  input  logic            mr_ni,
  output logic            sys_rst_no,
  output logic            rst_oe_o,
  output logic [NSRC:0]   cause_o
);
  logic [NSRC-1:0] bad;
  logic            pressed;
  logic            active;
  logic [NSRC:0]   src_vec;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (SRC_EN[i]) begin : g_on
      rst_sup_src_gate #(
        .LAT (int'(LAT_CYC[i*LAT_W +: LAT_W]))
      ) u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .flag_i (uv_flag_i[i]),
        .bad_o  (bad[i])
      );
    end else begin : g_off
      assign bad[i] = 1'b0;
    end
  end

  rst_sup_btn_qual #(
    .FILT_CYC (FILT_CYC),
    .HOLD_CYC (HOLD_CYC),
    .HOLD_EN  (HOLD_EN)
  ) u_btn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mr_ni     (mr_ni),
    .pressed_o (pressed)
  );

  assign src_vec = {pressed, bad};

  rst_sup_recovery #(
    .REC_CYC (REC_CYC)
  ) u_rec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (|src_vec),
    .active_o (active)
  );

  rst_sup_cause #(
    .W (NSRC + 1)
  ) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_vec),
    .cause_o (cause_o)
  );

  if (OPEN_DRAIN) begin : g_od
    assign sys_rst_no = 1'b0;
    assign rst_oe_o   = active;
  end else begin : g_pp
    assign sys_rst_no = ~active;
    assign rst_oe_o   = 1'b1;
  end

  AST_RELEASE_NEEDS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_vec != '0) |=> (OPEN_DRAIN ? rst_oe_o : !sys_rst_no)); // R6
endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
  localparam int REC  = 20;
  localparam int FILT = 4;
  localparam int HOLD = 10;
  localparam logic [2:0] EN = 3'b011;
  localparam int LAT [3] = '{3, 5, 4};
  localparam int THR [2] = '{FILT, FILT + HOLD};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] flag = '0;
  logic mr_a = 1'b1, mr_b = 1'b1;
  logic rst_a, oe_a, rst_b, oe_b;
  logic [3:0] cause_a, cause_b;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_supervisor #(.NSRC(3), .SRC_EN(EN), .LAT_CYC({16'd4, 16'd5, 16'd3}),
    .FILT_CYC(FILT), .HOLD_CYC(HOLD), .HOLD_EN(1'b0), .REC_CYC(REC), .OPEN_DRAIN(1'b0))
  uut (.clk_i(clk), .rst_ni(rst_n), .uv_flag_i(flag), .mr_ni(mr_a),
       .sys_rst_no(rst_a), .rst_oe_o(oe_a), .cause_o(cause_a));

  rst_supervisor #(.NSRC(3), .SRC_EN(EN), .LAT_CYC({16'd4, 16'd5, 16'd3}),
    .FILT_CYC(FILT), .HOLD_CYC(HOLD), .HOLD_EN(1'b1), .REC_CYC(REC), .OPEN_DRAIN(1'b1))
  uut_hold (.clk_i(clk), .rst_ni(rst_n), .uv_flag_i(flag), .mr_ni(mr_b),
       .sys_rst_no(rst_b), .rst_oe_o(oe_b), .cause_o(cause_b));

  // Reference state, built from the requirements
  int  run_hi [3];
  bit  m_bad  [3];
  int  run_lo [2];
  bit  m_prs  [2];
  int  clean  [2];
  bit  m_rq   [2];
  logic [3:0] m_cause [2];
  string phase = "R1";

  function automatic bit any_bad();
    return m_bad[0] | m_bad[1] | m_bad[2];
  endfunction

  function automatic bit exp_active(int j);
    return any_bad() | m_prs[j] | (clean[j] < REC);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin run_hi[i] = 0; m_bad[i] = 0; end
    for (int j = 0; j < 2; j++) begin
      run_lo[j] = 0; m_prs[j] = 0; clean[j] = 0; m_rq[j] = 0; m_cause[j] = '0;
    end
  endtask

  task automatic model_step();
    bit req_old;
    for (int j = 0; j < 2; j++) begin
      req_old = any_bad() | m_prs[j];
      if (req_old) clean[j] = 0;
      else if (clean[j] < REC) clean[j]++;
      if (req_old && !m_rq[j]) m_cause[j] = {m_prs[j], m_bad[2], m_bad[1], m_bad[0]};
      m_rq[j] = req_old;
    end
    for (int i = 0; i < 3; i++) begin
      run_hi[i] = flag[i] ? ((run_hi[i] < 1000) ? run_hi[i] + 1 : 1000) : 0;
      m_bad[i]  = EN[i] && (run_hi[i] >= LAT[i]);
    end
    run_lo[0] = !mr_a ? ((run_lo[0] < 1000) ? run_lo[0] + 1 : 1000) : 0;
    run_lo[1] = !mr_b ? ((run_lo[1] < 1000) ? run_lo[1] + 1 : 1000) : 0;
    for (int j = 0; j < 2; j++) m_prs[j] = run_lo[j] >= THR[j];
  endtask

  task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(phase, "rst_a", {3'b0, rst_a}, {3'b0, !exp_active(0)});
    check("R8",  "oe_a",  {3'b0, oe_a},  4'd1);
    check("R9",  "rst_b", {3'b0, rst_b}, 4'd0);
    check(phase, "oe_b",  {3'b0, oe_b},  {3'b0, exp_active(1)});
    check("R10", "cause_a", cause_a, m_cause[0]);
    check("R10", "cause_b", cause_b, m_cause[1]);
  endtask

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    phase = "R1";
    compare_all();                       // reset state
    rst_n = 1'b1;
    cyc(REC + 5);                         // R1: release at edge REC

    phase = "R2";
    flag[0] = 1; cyc(2); flag[0] = 0; cyc(3);   // too short: no effect
    flag[0] = 1; cyc(3); flag[0] = 0; cyc(REC + 3);
    flag[1] = 1; cyc(4); flag[1] = 0; cyc(2);   // one short of LAT1
    flag[1] = 1; cyc(7); flag[1] = 0; cyc(REC + 3);

    phase = "R3";
    flag[2] = 1; cyc(30); flag[2] = 0; cyc(3);

    phase = "R4";
    mr_a = 0; cyc(FILT - 1); mr_a = 1; cyc(4);
    mr_a = 0; cyc(FILT); mr_a = 1; cyc(REC + 3);

    phase = "R5";
    mr_b = 0; cyc(FILT + HOLD - 1); mr_b = 1; cyc(3);
    mr_b = 0; cyc(FILT + HOLD + 3); mr_b = 1; cyc(REC + 3);

    phase = "R7";
    flag[0] = 1; cyc(5); flag[0] = 0; cyc(REC - 2);
    flag[0] = 1; cyc(4); flag[0] = 0; cyc(REC - 1); cyc(3);

    phase = "R6";
    flag[0] = 1; mr_a = 0; mr_b = 0; cyc(8); flag[0] = 0; cyc(6);
    mr_a = 1; cyc(10); mr_b = 1; cyc(REC + 3);

    phase = "R10";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(15) == 0) flag[0] = ~flag[0];
      if ($urandom_range(15) == 0) flag[1] = ~flag[1];
      if ($urandom_range(15) == 0) flag[2] = ~flag[2];
      if ($urandom_range(7) == 0)  mr_a = ~mr_a;
      if ($urandom_range(9) == 0)  mr_b = ~mr_b;
      if ($urandom_range(200) == 0) begin flag = '0; mr_a = 1; mr_b = 1; cyc(REC + 2); end
      cyc();
    end
    finish_run();
  end
endmodule